// File: doc/BRIEF.md
# Streaming Traversal Cache Controller

This block feeds a pipelined datapath with the elements of a serialized pointer-structure traversal held in a cache memory. The host programs a base address, an element count, an address stride and a mode bit, then pulses a start input. In hit mode the elements already sit in the cache, and the controller reads them in order through a linear address generator. The cache read port returns data a fixed number of cycles after each read.

In miss mode the host pushes elements through a small input FIFO. Each element leaving the FIFO is written into the cache at its slot and handed to the datapath in the same pass. A host push that finds the FIFO full counts as an overflow. The overflowed element is dropped and the host path is closed. The FIFO contents drain to the datapath and the cache. The controller then fetches the remaining elements from the cache, starting at the index of the element that was lost.

A ready flag tells the host when the whole traversal has passed into the datapath. A separate level counter tracks how many results are waiting in the results memory, so the host can drain them while a run is in progress.

Top module: `trv_stream_ctrl`

## Requirements
- R1: After reset, ready is 1, dp_valid, dp_stall, mem_wen and mem_ren are 0, and res_level is 0.
- R2: In hit mode (cfg_hit=1) the k-th read, for k=0..len-1 in order, goes to address (base + k*stride) mod 2^AW. Its data appears on dp_data with dp_valid exactly RD_LAT=2 cycles after the read is issued.
- R3: In miss mode (cfg_hit=0) the k-th accepted host element is written to address (base + k*stride) mod 2^AW. The same value appears on dp_data with dp_valid one cycle after it leaves the FIFO, and the order is kept.
- R4: A host push while the FIFO (depth 4) is full and not being popped is dropped and closes the host path. The FIFO contents still go to the datapath and the cache. Cache reads then resume at index equal to the number of elements accepted before the overflow.
- R5: The controller issues exactly len minus (elements written) reads, and never reads an index at or beyond len.
- R6: While dp_hold is 1, no FIFO element is popped and no cache read is issued. Reads already in flight still deliver.
- R7: Ready falls at the edge that accepts start and rises one cycle after the last dp_valid. In hit mode with no hold, ready is back high len+2 edges after the start edge.
- R8: A start pulse while ready is 0 is ignored: the running traversal keeps its base, length and sequence.
- R9: A start pulse with cfg_len=0 is ignored: ready stays 1 and no element is produced.
- R10: dp_stall is 1 exactly when ready is 0 and dp_valid is 0.
- R11: res_level rises by one on res_push alone, falls by one on res_pop alone, and stays unchanged when both or neither are asserted. It saturates at 0 and at RES_DEPTH=8.
- R12: Host pushes while the controller is idle are discarded. The first element of a following miss run is the first element pushed after start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | AW | Cache address of element 0 |
| cfg_len | input | LW | Number of elements in the traversal |
| cfg_stride | input | SW | Address step between elements |
| cfg_hit | input | 1 | 1 = read from cache, 0 = load from host |
| start | input | 1 | Begin a traversal (acted on only when ready) |
| ready | output | 1 | Idle; previous traversal fully delivered |
| hw_valid | input | 1 | Host element push |
| hw_data | input | DW | Host element value |
| mem_wen | output | 1 | Cache write enable |
| mem_ren | output | 1 | Cache read enable |
| mem_addr | output | AW | Cache address |
| mem_wdata | output | DW | Cache write data |
| mem_rdata | input | DW | Cache read data, RD_LAT cycles after mem_ren |
| dp_hold | input | 1 | Datapath asks for no new elements |
| dp_valid | output | 1 | Element present on dp_data |
| dp_stall | output | 1 | Busy but no element this cycle |
| dp_data | output | DW | Element to datapath |
| res_push | input | 1 | Datapath wrote one result |
| res_pop | input | 1 | Host drained one result |
| res_level | output | RLW | Results memory fill level |

## Verification
Hit runs use unit stride, a wider stride with dp_hold toggling, and a base near the top of the address space so the addresses wrap. Together these separate address arithmetic from read-pipeline timing. Miss runs without hold show streaming writes alongside delivery. Miss runs with hold held across the first pushes force an overflow; one leaves several elements to fetch back from the cache and another leaves only one. This separates a correct fallback index from an off-by-one. A restart during a run, a zero-length start and host pushes while idle check that the controller ignores them.

// File: rtl/trv_pkg.sv
package trv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MISS  = 2'd1,
    ST_FLUSH = 2'd2,
    ST_READ  = 2'd3
  } trv_state_e;

  // element slot address: base + index * stride (caller truncates)
  function automatic logic [31:0] trv_addr(input logic [31:0] base,
                                           input logic [31:0] idx,
                                           input logic [31:0] stride);
    return base + idx * stride;
  endfunction

  // saturating up/down level step
  function automatic logic [15:0] lvl_next(input logic [15:0] lvl,
                                           input logic push,
                                           input logic pop,
                                           input logic [15:0] cap);
    if (push && !pop && lvl < cap) return lvl + 16'd1;
    if (pop && !push && lvl != 16'd0) return lvl - 16'd1;
    return lvl;
  endfunction

endpackage

// File: rtl/trv_fifo.sv
module trv_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          empty,
  output logic          full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] slots [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign rdata = slots[rp];

  always_ff @(posedge clk) begin
    if (push) slots[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      if (push && !pop)      cnt <= cnt + CW'(1);
      else if (pop && !push) cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/trv_rdpipe.sv
module trv_rdpipe #(
  parameter int LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  output logic vld
);
  logic [LAT-1:0] sh;

  generate
    if (LAT == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= issue;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[LAT-2:0], issue};
      end
    end
  endgenerate

  assign vld = sh[LAT-1];
endmodule

// File: rtl/trv_fill.sv
module trv_fill #(
  parameter int DEPTH = 8,
  parameter int LVW   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic           pop,
  output logic [LVW-1:0] level
);
  logic [15:0] nxt;

  assign nxt = trv_pkg::lvl_next(16'(level), push, pop, 16'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) level <= '0;
    else        level <= LVW'(nxt);
  end
endmodule

// File: rtl/trv_stream_ctrl.sv
module trv_stream_ctrl #(
  parameter int AW         = 10,
  parameter int DW         = 16,
  parameter int SW         = 4,
  parameter int LW         = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int RD_LAT     = 2,
  parameter int RES_DEPTH  = 8,
  localparam int RLW       = $clog2(RES_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  cfg_base,
  input  logic [LW-1:0]  cfg_len,
  input  logic [SW-1:0]  cfg_stride,
  input  logic           cfg_hit,
  input  logic           start,
  output logic           ready,
  input  logic           hw_valid,
  input  logic [DW-1:0]  hw_data,
  output logic           mem_wen,
  output logic           mem_ren,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           dp_hold,
  output logic           dp_valid,
  output logic           dp_stall,
  output logic [DW-1:0]  dp_data,
  input  logic           res_push,
  input  logic           res_pop,
  output logic [RLW-1:0] res_level
);
  import trv_pkg::*;

  trv_state_e    st;
  logic [AW-1:0] r_base;
  logic [LW-1:0] r_len;
  logic [SW-1:0] r_stride;
  logic [LW-1:0] acc_cnt;   // elements accepted into the FIFO
  logic [LW-1:0] wr_idx;    // elements written to the cache
  logic [LW-1:0] rd_idx;    // next cache read index
  logic [LW-1:0] dcnt;      // elements delivered
  logic          pv;
  logic [DW-1:0] pdata;
  logic          ready_q;

  // named internal events
  logic          fifo_push, fifo_pop, fifo_empty, fifo_full;
  logic [DW-1:0] fifo_head;
  logic          ovf_evt, rd_issue, rd_vld, last_dlv, start_ok;
  logic [AW-1:0] wr_addr, rd_addr;

  wire in_miss  = (st == ST_MISS);
  wire draining = (st == ST_MISS) || (st == ST_FLUSH);
  wire room     = (acc_cnt < r_len);

  assign fifo_pop  = draining && !fifo_empty && !dp_hold;
  assign fifo_push = hw_valid && in_miss && room && (!fifo_full || fifo_pop);
  assign ovf_evt   = hw_valid && in_miss && room && fifo_full && !fifo_pop;
  assign rd_issue  = (st == ST_READ) && (rd_idx < r_len) && !dp_hold;
  assign start_ok  = (st == ST_IDLE) && start && (cfg_len != '0);

  assign wr_addr = AW'(trv_addr(32'(r_base), 32'(wr_idx), 32'(r_stride)));
  assign rd_addr = AW'(trv_addr(32'(r_base), 32'(rd_idx), 32'(r_stride)));

  trv_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(fifo_push), .wdata(hw_data),
    .pop(fifo_pop), .rdata(fifo_head),
    .empty(fifo_empty), .full(fifo_full)
  );

  trv_rdpipe #(.LAT(RD_LAT)) u_rdpipe (
    .clk(clk), .rst_n(rst_n), .issue(rd_issue), .vld(rd_vld)
  );

  trv_fill #(.DEPTH(RES_DEPTH), .LVW(RLW)) u_fill (
    .clk(clk), .rst_n(rst_n), .push(res_push), .pop(res_pop), .level(res_level)
  );

  assign mem_wen   = fifo_pop;
  assign mem_wdata = fifo_head;
  assign mem_ren   = rd_issue;
  assign mem_addr  = fifo_pop ? wr_addr : rd_addr;

  assign dp_valid = pv | rd_vld;
  assign dp_data  = pv ? pdata : mem_rdata;
  assign ready    = ready_q;
  assign dp_stall = !ready_q && !dp_valid;
  assign last_dlv = dp_valid && (dcnt == r_len - LW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      r_base   <= '0;
      r_len    <= '0;
      r_stride <= '0;
      acc_cnt  <= '0;
      wr_idx   <= '0;
      rd_idx   <= '0;
      dcnt     <= '0;
      pv       <= 1'b0;
      pdata    <= '0;
      ready_q  <= 1'b1;
    end else begin
      pv    <= fifo_pop;
      pdata <= fifo_head;
      if (fifo_push) acc_cnt <= acc_cnt + LW'(1);
      if (fifo_pop)  wr_idx  <= wr_idx + LW'(1);
      if (rd_issue)  rd_idx  <= rd_idx + LW'(1);
      if (dp_valid)  dcnt    <= dcnt + LW'(1);

      unique case (st)
        ST_IDLE: begin
          if (start_ok) begin
            r_base   <= cfg_base;
            r_len    <= cfg_len;
            r_stride <= cfg_stride;
            acc_cnt  <= '0;
            wr_idx   <= '0;
            rd_idx   <= '0;
            dcnt     <= '0;
            ready_q  <= 1'b0;
            st       <= cfg_hit ? ST_READ : ST_MISS;
          end
        end
        ST_MISS: begin
          if (ovf_evt) begin
            st     <= ST_FLUSH;
            rd_idx <= acc_cnt;
          end
        end
        ST_FLUSH: begin
          if (fifo_empty) st <= ST_READ;
        end
        ST_READ: ;
        default: st <= ST_IDLE;
      endcase

      if (st != ST_IDLE && last_dlv) begin
        ready_q <= 1'b1;
        st      <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/trv_stream_ctrl_chk.sv
module trv_stream_ctrl_chk #(
  parameter int AW        = 10,
  parameter int LW        = 8,
  parameter int RLW       = 4,
  parameter int RES_DEPTH = 8,
  parameter int RD_LAT    = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ready,
  input logic           start,
  input logic [LW-1:0]  cfg_len,
  input logic           mem_wen,
  input logic           mem_ren,
  input logic           dp_hold,
  input logic           dp_valid,
  input logic           dp_stall,
  input logic [RLW-1:0] res_level,
  input logic [AW-1:0]  r_base,
  input logic [LW-1:0]  r_len,
  input logic           ovf_evt,
  input logic           fifo_push
);
  a_r10_stall_excl: assert property (@(posedge clk) disable iff (!rst_n)
    dp_stall |-> !dp_valid && !ready);

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !mem_ren && !mem_wen);

  a_r5_one_port_op: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_ren && mem_wen));

  a_r6_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    dp_hold |-> !mem_ren && !mem_wen);

  a_r2_r3_source: assert property (@(posedge clk) disable iff (!rst_n)
    dp_valid |-> ($past(mem_ren, RD_LAT) || $past(mem_wen)));

  a_r7_ready_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(dp_valid));

  a_r8_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && start) |=> $stable(r_base) && $stable(r_len));

  a_r9_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && start && cfg_len == '0) |=> ready);

  a_r4_host_closed: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> !fifo_push);

  a_r11_level_cap: assert property (@(posedge clk) disable iff (!rst_n)
    res_level <= RLW'(RES_DEPTH));
endmodule

bind trv_stream_ctrl trv_stream_ctrl_chk #(
  .AW(AW), .LW(LW), .RLW(RLW), .RES_DEPTH(RES_DEPTH), .RD_LAT(RD_LAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .start(start), .cfg_len(cfg_len),
  .mem_wen(mem_wen), .mem_ren(mem_ren), .dp_hold(dp_hold),
  .dp_valid(dp_valid), .dp_stall(dp_stall), .res_level(res_level),
  .r_base(r_base), .r_len(r_len), .ovf_evt(ovf_evt), .fifo_push(fifo_push)
);

// File: tb/trv_stream_ctrl_test.sv
module trv_stream_ctrl_test;
  localparam int CLK_P = 10;
  localparam int AW = 10, DW = 16, SW = 4, LW = 8, RLW = 4;

  typedef struct packed {
    logic       hit;
    logic [9:0] base;
    logic [7:0] len;
    logic [3:0] stride;
    logic [1:0] hold;    // 0 none, 1 toggle, 2 high for first 8 cycles
    logic [7:0] exp_wr;  // expected cache writes
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 10'd10,   8'd3, 4'd1, 2'd0, 8'd0},
    '{1'b1, 10'd100,  8'd5, 4'd3, 2'd1, 8'd0},
    '{1'b0, 10'd200,  8'd4, 4'd1, 2'd0, 8'd4},
    '{1'b0, 10'd300,  8'd9, 4'd2, 2'd2, 8'd4},
    '{1'b1, 10'd1020, 8'd6, 4'd1, 2'd0, 8'd0},
    '{1'b0, 10'd50,   8'd1, 4'd5, 2'd0, 8'd1},
    '{1'b0, 10'd600,  8'd5, 4'd7, 2'd2, 8'd4}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [LW-1:0] cfg_len = '0;
  logic [SW-1:0] cfg_stride = '0;
  logic cfg_hit = 1'b0, start = 1'b0, ready;
  logic hw_valid = 1'b0;
  logic [DW-1:0] hw_data = '0;
  logic mem_wen, mem_ren;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, rd1;
  logic dp_hold = 1'b0, dp_valid, dp_stall;
  logic [DW-1:0] dp_data;
  logic res_push = 1'b0, res_pop = 1'b0;
  logic [RLW-1:0] res_level;

  logic [DW-1:0] mem [0:1023];
  int nchk = 0, nfail = 0;

  always #(CLK_P/2) clk = ~clk;

  // cache model: two-cycle read latency, contents preloaded by the bench
  always @(posedge clk) begin
    rd1       <= mem[mem_addr];
    mem_rdata <= rd1;
  end

  trv_stream_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_len(cfg_len),
    .cfg_stride(cfg_stride), .cfg_hit(cfg_hit), .start(start), .ready(ready),
    .hw_valid(hw_valid), .hw_data(hw_data), .mem_wen(mem_wen), .mem_ren(mem_ren),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dp_hold(dp_hold), .dp_valid(dp_valid), .dp_stall(dp_stall), .dp_data(dp_data),
    .res_push(res_push), .res_pop(res_pop), .res_level(res_level)
  );

  function automatic logic [15:0] hv(input int tag, input int k);
    return {tag[7:0], k[7:0]};
  endfunction

  function automatic logic [9:0] ea(input int b, input int k, input int s);
    int t;
    t = b + k * s;
    return t[9:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input int tag, input bit hit, input int base, input int len,
                     input int stride, input int hold, input int exp_wr,
                     input bit restart);
    int dcount = 0, wcount = 0, rcount = 0, end_cyc = 0;
    bit bad_data = 0, bad_wr = 0, bad_rd = 0, bad_stall = 0, bad_hold = 0;
    for (int a = 0; a < 1024; a++) mem[a] = '0;
    for (int k = 0; k < len; k++) mem[ea(base, k, stride)] = hv(tag, k);
    cfg_base   = AW'(base);
    cfg_len    = LW'(len);
    cfg_stride = SW'(stride);
    cfg_hit    = hit;
    for (int cyc = 0; cyc < 400; cyc++) begin
      @(negedge clk);
      start = (cyc == 0) || (restart && cyc == 2);
      if (restart && cyc == 2) begin
        cfg_base = AW'(base + 5);
        cfg_len  = LW'(len + 2);
      end
      hw_valid = !hit && cyc >= 1 && cyc <= len;
      hw_data  = hv(tag, cyc - 1);
      dp_hold  = (hold == 1) ? cyc[0] : (hold == 2) ? (cyc < 8) : 1'b0;
      #1;
      if (cyc == 1) chk(!ready, "R7 ready low after start", int'(ready), 0);
      if (cyc == 1 && hit) chk(dp_stall, "R10 stall before first read data", int'(dp_stall), 1);
      if (!ready && (dp_stall == dp_valid)) bad_stall = 1;
      if (dp_hold && (mem_ren || mem_wen)) bad_hold = 1;
      if (dp_valid) begin
        if (dp_data != hv(tag, dcount)) begin
          bad_data = 1;
          $display("FAIL R2/R3 element %0d actual=%0h expected=%0h", dcount, dp_data, hv(tag, dcount));
        end
        dcount++;
      end
      if (mem_wen) begin
        if (mem_addr != ea(base, wcount, stride) || mem_wdata != hv(tag, wcount)) bad_wr = 1;
        wcount++;
      end
      if (mem_ren) begin
        if (mem_addr != ea(base, exp_wr + rcount, stride)) bad_rd = 1;
        rcount++;
      end
      if (cyc > 0 && ready) begin
        end_cyc = cyc;
        break;
      end
    end
    @(negedge clk);
    start = 0; hw_valid = 0; dp_hold = 0;
    chk(end_cyc > 0, "R7 ready returns", end_cyc, 1);
    chk(!bad_data && dcount == len, hit ? "R2 delivered sequence" : "R3 delivered sequence", dcount, len);
    chk(!bad_wr && wcount == exp_wr, exp_wr < len && !hit ? "R4 cache writes" : "R3 cache writes", wcount, exp_wr);
    chk(!bad_rd && rcount == len - exp_wr, "R5 read count and addresses", rcount, len - exp_wr);
    chk(!bad_stall, "R10 stall consistency", int'(bad_stall), 0);
    chk(!bad_hold, "R6 nothing issued under hold", int'(bad_hold), 0);
    if (hit && hold == 0 && !restart) chk(end_cyc == len + 3, "R7 hit latency", end_cyc, len + 3);
    if (restart) chk(dcount == len, "R8 restart ignored", dcount, len);
  endtask

  initial begin
    #(CLK_P * 100000);
    nfail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(ready && !dp_valid && !dp_stall && !mem_wen && !mem_ren && res_level == 0,
        "R1 reset state", {ready, dp_valid, dp_stall, mem_wen, mem_ren}, 5'b10000);

    // table walk: hit, miss, overflow, wrap, single element
    for (int v = 0; v < NV; v++)
      run(16 + v, VECS[v].hit, int'(VECS[v].base), int'(VECS[v].len),
          int'(VECS[v].stride), int'(VECS[v].hold), int'(VECS[v].exp_wr), 1'b0);

    // R9: zero-length start is ignored
    @(negedge clk);
    cfg_len = '0; cfg_hit = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      bit seen = 0;
      for (int i = 0; i < 5; i++) begin
        #1;
        if (!ready || dp_valid) seen = 1;
        @(negedge clk);
      end
      chk(!seen, "R9 zero length leaves ready high", int'(seen), 0);
    end

    // R8: start during a run is ignored
    run(40, 1'b1, 10, 3, 1, 0, 0, 1'b1);

    // R12: host pushes while idle are discarded
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      hw_valid = 1'b1; hw_data = 16'hDEAD;
    end
    @(negedge clk);
    hw_valid = 1'b0;
    run(41, 1'b0, 700, 3, 1, 0, 3, 1'b0);  // R12: first delivered must be element 0

    // R11: results level
    @(negedge clk); res_push = 1'b1;
    repeat (2) @(negedge clk);
    @(negedge clk); res_push = 1'b0; #1;
    chk(res_level == 3, "R11 push count", res_level, 3);
    @(negedge clk); res_push = 1'b1; res_pop = 1'b1;
    @(negedge clk); res_push = 1'b0; res_pop = 1'b0; #1;
    chk(res_level == 3, "R11 push and pop together", res_level, 3);
    @(negedge clk); res_pop = 1'b1;
    @(negedge clk); res_pop = 1'b0; #1;
    chk(res_level == 2, "R11 pop", res_level, 2);
    @(negedge clk); res_pop = 1'b1;
    repeat (4) @(negedge clk);
    res_pop = 1'b0; #1;
    chk(res_level == 0, "R11 floor at zero", res_level, 0);
    @(negedge clk); res_push = 1'b1;
    repeat (11) @(negedge clk);
    res_push = 1'b0; #1;
    chk(res_level == 8, "R11 ceiling", res_level, 8);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule